// File: doc/BRIEF.md
# MII Management Command Engine

This block drives the two-wire PHY management bus (a clock, MDC, and a shared data line, MDIO) from one 32-bit command/status word. The host writes the whole word in one access. The word holds the operation code, the PHY address, the register address and, for a write, the data. That write clears the ready flag and launches a complete management frame. The host then polls the same word. When the ready flag returns, a read operation has placed the PHY's answer in the low half-word. A level output carries the ready flag, so it can serve as a completion signal.

A frame always lasts 64 MDC periods. MDC is produced only while a frame is running. Each half period of MDC lasts `MDC_HALF` system clocks. The engine changes MDIO only on the falling edge of MDC and samples MDIO only on the rising edge. A command word written while a frame is running is dropped.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `rd_data` reads 0x1000_0000 (only bit 28 set), `ready_o` is 1, `mdc` is 0 and `mdio_oe` is 0.
- R2: A write when the ready flag is 1 stores the command word. In the cycle after the write edge, `rd_data` shows bits 27:26 as the opcode, 25:21 as the PHY address, 20:16 as the register address and 15:0 as the data, with bit 28 at 0 and bits 31:29 at 0.
- R3: Every frame sends, MSB first, 32 ones, the start code 01, the two opcode bits, the five PHY address bits and the five register address bits (bit positions 0 to 45). MDIO changes only when MDC falls, so it is stable at each MDC rise.
- R4: For an opcode other than 10, bit positions 46 and 47 are 1 then 0. The 16 data bits follow MSB first. `mdio_oe` is 1 for all 64 positions.
- R5: For opcode 10 (read), `mdio_oe` is 0 for positions 46 to 63. The values on `mdio_in` at the MDC rises of positions 48 to 63 are collected MSB first. At completion they appear in `rd_data[15:0]`.
- R6: While a frame runs, MDC has a period of 2*`MDC_HALF` system clocks. Its first rise comes `MDC_HALF` clocks after the write edge. While idle, MDC is 0.
- R7: The ready flag (bit 28 and `ready_o`) returns to 1 exactly 128*`MDC_HALF` clocks after the write edge. It stays at 1 until the next accepted write. For a write operation, `rd_data[15:0]` keeps the written data.
- R8: A write while the ready flag is 0 is ignored: the stored fields do not change, the frame on the bus does not change, and the completion time does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| rd_data | output | 32 | Command/status word readback |
| ready_o | output | 1 | Level copy of the ready flag |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data driven onto MDIO |
| mdio_oe | output | 1 | Drive enable for MDIO |
| mdio_in | input | 1 | Data seen on MDIO |

## Verification
The stored fields and the cleared ready flag are due one cycle after the write edge. The bench samples 1 ns after that edge. The ready flag is due exactly 128*`MDC_HALF` edges later. The bench therefore counts edges from the write and checks that the flag is still 0 one edge before that point and is 1 at that point. Bus bits are captured at each MDC rise, where the rules guarantee they are stable. The bench PHY drives read data at MDC falls. The bench checks the first two MDC rise times against the requirement R6 period. An ignored write is placed mid-frame, and the bench checks the stored fields, the frame contents and the completion time all at the ports.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
  localparam int FRAME_LEN = 64;
  localparam int TA_POS    = 46;
  localparam int DATA_POS  = 48;
  localparam logic [1:0] OP_READ = 2'b10;

  function automatic logic cmd_is_read(input logic [1:0] op);
    return op == OP_READ;
  endfunction

  function automatic logic [FRAME_LEN-1:0] mdio_build_frame(
      input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] dat);
    return {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, dat};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int MDC_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick     = run && (cnt == CW'(MDC_HALF - 1));
  assign rise_stb = tick && !mdc;
  assign fall_stb = tick && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6
  mdc_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> mdc);
  // R6
  mdc_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_frame_shift.sv
module mdio_frame_shift
  import mdio_cmd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_LEN-1:0] frame_in,
  input  logic                 rd_in,
  input  logic                 rise,
  input  logic                 fall,
  input  logic                 mdio_in,
  output logic                 active,
  output logic                 mdio_out,
  output logic                 mdio_oe,
  output logic [15:0]          rx_data,
  output logic                 done
);
  logic [FRAME_LEN-1:0] sr;
  logic [5:0]           bitcnt;
  logic                 rd_q;

  assign done     = active && fall && (bitcnt == 6'(FRAME_LEN - 1));
  assign mdio_oe  = active && !(rd_q && (bitcnt >= 6'(TA_POS)));
  assign mdio_out = mdio_oe ? sr[FRAME_LEN-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr      <= '0;
      bitcnt  <= '0;
      rd_q    <= 1'b0;
      active  <= 1'b0;
      rx_data <= '0;
    end else if (start) begin
      sr     <= frame_in;
      bitcnt <= '0;
      rd_q   <= rd_in;
      active <= 1'b1;
    end else if (active) begin
      if (rise && (bitcnt >= 6'(DATA_POS)))
        rx_data <= {rx_data[14:0], mdio_in};
      if (fall) begin
        if (done) begin
          active <= 1'b0;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          sr     <= {sr[FRAME_LEN-2:0], 1'b0};
        end
      end
    end
  end

  // R3
  mdio_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$stable(mdio_out)) |-> $past(fall));
  // R2
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (active && bitcnt == 6'd0));
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_cmd_pkg::*;
#(
  parameter int MDC_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        ready_o,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic [1:0]  op_q;
  logic [4:0]  phy_q, reg_q;
  logic [15:0] dat_q;
  logic        ready_q;
  logic        start_w, done_w, busy_w, rise_w, fall_w;
  logic [15:0] rx_w;
  logic [2:0]  unused_hi_bits;

  assign unused_hi_bits = wr_data[31:29];
  assign start_w = wr_en && ready_q;
  assign rd_data = {3'b000, ready_q, op_q, phy_q, reg_q, dat_q};
  assign ready_o = ready_q;

  mdio_clk_gen #(.MDC_HALF(MDC_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy_w),
    .mdc(mdc), .rise_stb(rise_w), .fall_stb(fall_w)
  );

  mdio_frame_shift u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_w),
    .frame_in(mdio_build_frame(wr_data[27:26], wr_data[25:21],
                               wr_data[20:16], wr_data[15:0])),
    .rd_in(cmd_is_read(wr_data[27:26])),
    .rise(rise_w), .fall(fall_w), .mdio_in(mdio_in),
    .active(busy_w), .mdio_out(mdio_out), .mdio_oe(mdio_oe),
    .rx_data(rx_w), .done(done_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
      dat_q   <= '0;
      ready_q <= 1'b1;
    end else if (start_w) begin
      op_q    <= wr_data[27:26];
      phy_q   <= wr_data[25:21];
      reg_q   <= wr_data[20:16];
      dat_q   <= wr_data[15:0];
      ready_q <= 1'b0;
    end else if (done_w) begin
      ready_q <= 1'b1;
      if (cmd_is_read(op_q)) dat_q <= rx_w;
    end
  end

  // R7
  ready_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> ready_q);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (!ready_q && busy_w));
  // R8
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ready_q && !done_w) |=> $stable({op_q, phy_q, reg_q, dat_q}));
  // R7
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> ready_q);
endmodule

// File: tb/sim_mdio_cmd_engine.sv
`timescale 1ns/1ps
module sim_mdio_cmd_engine;
  localparam int HALF = 2;
  localparam int DONE_CYC = 128 * HALF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        ready_o, mdc, mdio_out, mdio_oe;
  logic        mdio_in = 1'b1;

  int checks = 0;
  int errors = 0;
  int nb = 0;
  logic [15:0] phydat = '0;
  logic cap_b [64];
  logic cap_oe [64];
  time  rt [64];

  always #2 clk = ~clk;

  mdio_cmd_engine #(.MDC_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .ready_o(ready_o), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  always @(posedge mdc) begin
    if (nb < 64) begin
      cap_b[nb]  = mdio_out;
      cap_oe[nb] = mdio_oe;
      rt[nb]     = $time;
    end
    nb = nb + 1;
  end

  always @(negedge mdc) begin
    if (nb >= 48 && nb < 64) mdio_in = phydat[63 - nb];
    else mdio_in = 1'b1;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] rg, input logic [15:0] dat,
                           input logic [15:0] pd, input bit poke_busy);
    logic [63:0] exp_f;
    logic [31:0] exp_w;
    bit rd;
    int bad_b, bad_oe;
    rd = (op == 2'b10);
    phydat = pd;
    nb = 0;
    exp_w = {3'b000, 1'b0, op, phy, rg, dat};
    exp_f = {32'hFFFF_FFFF, 2'b01, op, phy, rg, 2'b10, dat};
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {3'b111, 1'b1, op, phy, rg, dat};
    @(posedge clk); #1;
    wr_en = 1'b0;
    chk("R2 fields after write", 64'(rd_data), 64'(exp_w));
    for (int k = 1; k < DONE_CYC; k++) begin
      @(posedge clk); #1;
      if (poke_busy && k == 40) begin
        wr_en = 1'b1;
        wr_data = ~{3'b111, 1'b1, op, phy, rg, dat};
      end
      if (poke_busy && k == 41) begin
        wr_en = 1'b0;
        chk("R8 busy write ignored", 64'(rd_data), 64'(exp_w));
      end
    end
    chk("R7 not ready one cycle early", 64'(ready_o), 64'd0);
    @(posedge clk); #1;
    chk("R7 ready at completion", 64'({ready_o, rd_data[28]}), 64'b11);
    exp_w[28] = 1'b1;
    if (rd) exp_w[15:0] = pd;
    chk(rd ? "R5 read data returned" : "R7 write data kept", 64'(rd_data), 64'(exp_w));
    chk("R6 mdc idle low", 64'({mdc, mdio_oe}), 64'd0);
    chk("R6 rise count", 64'(nb), 64'd64);
    chk("R6 mdc period", 64'(rt[1] - rt[0]), 64'(2 * HALF * 4));
    bad_b = 0; bad_oe = 0;
    for (int i = 0; i < 64; i++) begin
      if (cap_oe[i] !== ((rd && i >= 46) ? 1'b0 : 1'b1)) bad_oe++;
      if (!(rd && i >= 46) && cap_b[i] !== exp_f[63 - i]) bad_b++;
    end
    chk(rd ? "R3 R5 frame bits" : "R3 R4 frame bits", 64'(bad_b), 64'd0);
    chk(rd ? "R5 drive release" : "R4 drive enable", 64'(bad_oe), 64'd0);
    repeat (5) @(posedge clk); #1;
    chk("R7 ready holds", 64'(ready_o), 64'd1);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 reset word", 64'(rd_data), 64'h1000_0000);
    chk("R1 reset pins", 64'({ready_o, mdc, mdio_oe}), 64'b100);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    run_frame(2'b01, 5'h0A, 5'h13, 16'hBEEF, 16'h0000, 1'b0);
    run_frame(2'b10, 5'h01, 5'h02, 16'h0000, 16'hA5C3, 1'b0);
    run_frame(2'b10, 5'h1F, 5'h1F, 16'h1234, 16'hFFFF, 1'b0);
    run_frame(2'b01, 5'h00, 5'h00, 16'h0000, 16'h0000, 1'b0);
    run_frame(2'b10, 5'h15, 5'h0A, 16'h0000, 16'h8001, 1'b1);
    run_frame(2'b01, 5'h11, 5'h05, 16'h5A5A, 16'h0000, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule